// File: doc/BRIEF.md
# MDIO Management Controller

This block is a management-bus master that lets a host reach PHY management registers over the two-wire MDC/MDIO serial link. The host sees four 32-bit registers on a simple write strobe plus combinational read-back bus: a configuration/status word, a control word, a data word and an extended-address word. A single framing engine builds every transaction: a run of preamble ones, start and opcode bits, the port and device (or register) addresses, a two-bit turnaround and sixteen data bits. One bit in the configuration word selects the classic short-address framing (Clause 22) or the extended framing (Clause 45).

The host picks the framing and the MDC divider, loads the port and device addresses, and then starts a frame. In extended mode, writing the extended-address word launches an address frame. Writing the data word launches a write frame. Writing the control word with its read bit set launches a read frame. Address frames are flagged by a status busy bit. Write and read frames are flagged by a busy bit in the data word. A read that the PHY does not acknowledge during turnaround raises a read-error flag and returns all ones.

The engine FSM has the states `ST_IDLE`, `ST_PRE` (preamble), `ST_HDR` (start, opcode and both addresses), `ST_TA` (turnaround) and `ST_DATA`. The transitions are:
- `ST_IDLE` to `ST_PRE` on an accepted launch.
- `ST_PRE` to `ST_HDR` after the last preamble bit.
- `ST_HDR` to `ST_TA` after the fourteenth header bit.
- `ST_TA` to `ST_DATA` after the second turnaround bit.
- `ST_DATA` to `ST_IDLE` after the sixteenth data bit.

Every transition takes place on a falling MDC edge.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration word at offset 0x0 reads 0x00000080. In that value the polarity bit 7 is 1, the divider field [24:16] is 0, the framing bit 6 is 0, and status bits 1 (read error) and 0 (address busy) are 0. MDC is low and MDIO is released (output enable low).
- R2: MDC high and low phases each last exactly the divider value in system clocks, so one MDC period is twice the divider. With the divider at 0, MDC stays low and no write that would launch a frame starts one. Such a write still stores its value.
- R3: With framing bit 0, a write to the data word (offset 0x8, data in bits [15:0]) sends 32 ones, then 01, then 01. Next come the 5-bit port (control bits [9:5]) and the 5-bit register number (control bits [4:0]), both MSB first. The frame ends with 10 and the 16 data bits, MSB first.
- R4: With framing bit 0, a control write (offset 0x4) with bit 15 set sends a read frame with opcode 10 and the new port and register fields. The controller releases MDIO for both turnaround bits and all 16 data bits. The sampled bits then read back in data-word bits [15:0].
- R5: With framing bit 1, a write to the address word (offset 0xC, bits [15:0]) sends 32 ones, 00, 00, the port, the device, 10 and the 16 address bits. Status bit 0 is set while this frame runs and data-word bit 31 stays clear. With framing bit 0, the same write only stores the value.
- R6: With framing bit 1, write frames use start 00 and opcode 01, and read frames use start 00 and opcode 11. All other fields are as in R3 and R4.
- R7: Data-word bit 31 is set from the clock after a write or read launch until that frame ends. It is never set together with status bit 0.
- R8: If MDIO is not low when sampled in the second turnaround bit of a read, status bit 1 is set and the data word reads 0xFFFF. Status bit 1 clears at the start of the next read.
- R9: While either busy flag is set, host writes to any of the four words are ignored. No stored field changes and no extra frame starts.
- R10: MDIO output and output enable change only while MDC is low. Frame bits are sampled on the rising MDC edge. MDIO is released whenever no frame runs.
- R11: Polarity bit 7 of the configuration word is writable and reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 4 | Host byte offset (0x0 config, 0x4 control, 0x8 data, 0xC address) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read-back of the word selected by bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable, low releases the line |
| mdio_i | input | 1 | MDIO line value as seen by the controller |

## Verification
The engine is run through short-address write and read frames, extended address, write and read frames, an unanswered read followed by an answered one, and a launch attempt with the divider at zero. Each frame's sampled bit stream is compared with the expected layout. This comparison separates opcode and start-bit mistakes between the two framings and shows whether the port and device fields land in the right order. A behavioural PHY responder answers reads with distinct data patterns, which exposes bit-order and capture-edge errors. The unanswered read shows whether the read-error flag and the all-ones substitution work, and the answered read after it shows whether the flag clears. A reference check on every clock tracks the output enable against the bit position and measures the MDC period with divider values 2 and 3. Host writes issued mid-frame show whether the busy gating protects every stored field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    typedef enum logic [1:0] {
        FR_ADDR,
        FR_WRITE,
        FR_READ
    } frame_kind_e;

    // word select, taken from bus_addr[3:2]
    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_ADDR = 2'd3;

    // field positions
    localparam int CFG_ABUSY_BIT = 0;
    localparam int CFG_ERR_BIT   = 1;
    localparam int CFG_C45_BIT   = 6;
    localparam int CFG_POL_BIT   = 7;
    localparam int CFG_DIV_LSB   = 16;
    localparam int CTRL_RD_BIT   = 15;
    localparam int DATA_BUSY_BIT = 31;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             div_nz;

    assign div_nz = (div != '0);
    assign tick   = run && div_nz && (cnt_q == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  frame_kind_e kind,
    input  logic        c45,
    input  logic [4:0]  port,
    input  logic [4:0]  dev,
    input  logic [15:0] wdata,
    input  logic        tick,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output frame_kind_e cur_kind,
    output logic        ta_err,
    output logic [15:0] rd_data
);

    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_END = CNT_W'(PRE_BITS + 13);
    localparam logic [CNT_W-1:0] TA_END  = CNT_W'(PRE_BITS + 15);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(PRE_BITS + 31);

    mdio_state_e           state_q, state_d;
    logic [CNT_W-1:0]      bit_q;
    logic [FRAME_BITS-1:0] shift_q;
    frame_kind_e           kind_q;
    logic                  mdc_q;
    logic                  err_q;
    logic [15:0]           cap_q;
    logic [1:0]            st_bits, op_bits;
    logic                  rise, fall;

    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;

    // start and opcode bits for the frame being launched
    always_comb begin
        st_bits = c45 ? 2'b00 : 2'b01;
        unique case (kind)
            FR_ADDR:  op_bits = 2'b00;
            FR_WRITE: op_bits = 2'b01;
            FR_READ:  op_bits = c45 ? 2'b11 : 2'b10;
            default:  op_bits = 2'b00;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                  state_d = ST_PRE;
            ST_PRE:  if (fall && bit_q == PRE_END) state_d = ST_HDR;
            ST_HDR:  if (fall && bit_q == HDR_END) state_d = ST_TA;
            ST_TA:   if (fall && bit_q == TA_END)  state_d = ST_DATA;
            ST_DATA: if (fall && bit_q == LAST)    state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, bit count, MDC and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            kind_q  <= FR_WRITE;
            mdc_q   <= 1'b0;
            err_q   <= 1'b0;
            cap_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            mdc_q <= 1'b0;
            if (start) begin
                shift_q <= {{PRE_BITS{1'b1}}, st_bits, op_bits, port, dev, 2'b10, wdata};
                bit_q   <= '0;
                kind_q  <= kind;
                err_q   <= 1'b0;
                cap_q   <= '0;
            end
        end else if (rise) begin
            mdc_q <= 1'b1;
            if (state_q == ST_TA && bit_q == TA_END) err_q <= mdio_i;
            if (state_q == ST_DATA && kind_q == FR_READ) cap_q <= {cap_q[14:0], mdio_i};
        end else if (fall) begin
            mdc_q   <= 1'b0;
            shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
            bit_q   <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PRE, ST_HDR: begin
                mdio_o  = shift_q[FRAME_BITS-1];
                mdio_oe = 1'b1;
            end
            ST_TA, ST_DATA: begin
                mdio_o  = shift_q[FRAME_BITS-1];
                mdio_oe = (kind_q != FR_READ);
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign mdc      = mdc_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = fall && (state_q == ST_DATA) && (bit_q == LAST);
    assign cur_kind = kind_q;
    assign ta_err   = err_q;
    assign rd_data  = cap_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W    = 9,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic             c45_q, pol_q, err_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       port_q, dev_q;
    logic [15:0]      data_q, addr_q;

    logic        eng_busy, eng_done, ta_err, tick;
    frame_kind_e cur_kind;
    logic [15:0] rd_data;
    logic        addr_busy, data_busy;

    logic        wr_ok, start;
    frame_kind_e l_kind;
    logic [4:0]  l_port, l_dev;
    logic [15:0] l_data;
    logic [1:0]  sel;
    logic        unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:25]};
    assign sel         = bus_addr[3:2];
    assign wr_ok       = bus_wr && !eng_busy;
    assign addr_busy   = eng_busy && (cur_kind == FR_ADDR);
    assign data_busy   = eng_busy && (cur_kind != FR_ADDR);

    // launch decode
    always_comb begin
        start  = 1'b0;
        l_kind = FR_WRITE;
        l_port = port_q;
        l_dev  = dev_q;
        l_data = data_q;
        if (wr_ok && div_q != '0) begin
            unique case (sel)
                SEL_CFG: ;
                SEL_CTRL: if (bus_wdata[CTRL_RD_BIT]) begin
                    start  = 1'b1;
                    l_kind = FR_READ;
                    l_port = bus_wdata[9:5];
                    l_dev  = bus_wdata[4:0];
                end
                SEL_DATA: begin
                    start  = 1'b1;
                    l_kind = FR_WRITE;
                    l_data = bus_wdata[15:0];
                end
                SEL_ADDR: if (c45_q) begin
                    start  = 1'b1;
                    l_kind = FR_ADDR;
                    l_data = bus_wdata[15:0];
                end
                default: ;
            endcase
        end
    end

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c45_q  <= 1'b0;
            pol_q  <= 1'b1;
            div_q  <= '0;
            err_q  <= 1'b0;
            port_q <= '0;
            dev_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
        end else begin
            if (wr_ok) begin
                unique case (sel)
                    SEL_CFG: begin
                        c45_q <= bus_wdata[CFG_C45_BIT];
                        pol_q <= bus_wdata[CFG_POL_BIT];
                        div_q <= bus_wdata[CFG_DIV_LSB +: DIV_W];
                    end
                    SEL_CTRL: begin
                        port_q <= bus_wdata[9:5];
                        dev_q  <= bus_wdata[4:0];
                    end
                    SEL_DATA: data_q <= bus_wdata[15:0];
                    SEL_ADDR: addr_q <= bus_wdata[15:0];
                    default: ;
                endcase
            end
            if (start && l_kind == FR_READ) begin
                err_q <= 1'b0;
            end else if (eng_done && cur_kind == FR_READ) begin
                err_q  <= ta_err;
                data_q <= ta_err ? 16'hFFFF : rd_data;
            end
        end
    end

    // read-back
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CFG: begin
                bus_rdata[CFG_ABUSY_BIT]          = addr_busy;
                bus_rdata[CFG_ERR_BIT]            = err_q;
                bus_rdata[CFG_C45_BIT]            = c45_q;
                bus_rdata[CFG_POL_BIT]            = pol_q;
                bus_rdata[CFG_DIV_LSB +: DIV_W]   = div_q;
            end
            SEL_CTRL: bus_rdata[9:0] = {port_q, dev_q};
            SEL_DATA: begin
                bus_rdata[15:0]          = data_q;
                bus_rdata[DATA_BUSY_BIT] = data_busy;
            end
            SEL_ADDR: bus_rdata[15:0] = addr_q;
            default: ;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .div   (div_q),
        .tick  (tick)
    );

    mdio_engine #(.PRE_BITS(PRE_BITS)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (l_kind),
        .c45      (c45_q),
        .port     (l_port),
        .dev      (l_dev),
        .wdata    (l_data),
        .tick     (tick),
        .mdio_i   (mdio_i),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (eng_busy),
        .done     (eng_done),
        .cur_kind (cur_kind),
        .ta_err   (ta_err),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             addr_busy,
    input logic             data_busy,
    input logic [DIV_W-1:0] div_q,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [9:0]       ctrl_bits
);

    // R2
    div_zero_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !mdc);

    // R10
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_busy || data_busy) |-> (!mdio_oe && !mdc));

    // R7
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_busy && data_busy));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (addr_busy || data_busy) && bus_addr[3:2] == SEL_CTRL) |=> $stable(ctrl_bits));

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .addr_busy (addr_busy),
    .data_busy (data_busy),
    .div_q     (div_q),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ctrl_bits ({port_q, dev_q})
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv, phy_val;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_master i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    localparam logic [3:0] A_CFG = 4'h0, A_CTRL = 4'h4, A_DATA = 4'h8, A_ADDR = 4'hC;

    int   checks = 0, fails = 0, cyc = 0;
    bit   bits[$];
    int   exp_div = 0;
    bit   frame_active = 0, is_rd_exp = 0, respond = 0;
    logic [15:0] resp = '0;
    int   r10_bad = 0, oe_bad = 0, per_bad = 0, last_rise = -1, rise_cnt = 0;
    logic prev_mdc = 0, prev_o = 1, prev_oe = 0;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model and PHY responder, evaluated every clock at the falling edge
    always @(negedge clk) begin
        int n, idx;
        bit rd, exp_oe;
        if (rst_n) begin
            if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) r10_bad++;
            if (mdc && !prev_mdc) begin
                bits.push_back(mdio_i);
                rise_cnt++;
                if (last_rise >= 0 && (cyc - last_rise) != 2 * exp_div) per_bad++;
                last_rise = cyc;
            end
            if (!mdc && prev_mdc) begin
                n  = bits.size();
                rd = (n > 34) && bits[34];
                if (respond && rd && n == 47) begin
                    phy_drv = 1'b1; phy_val = 1'b0;
                end else if (respond && rd && n >= 48 && n <= 63) begin
                    phy_drv = 1'b1; phy_val = resp[63 - n];
                end else begin
                    phy_drv = 1'b0;
                end
            end
            if (frame_active) begin
                n   = bits.size();
                idx = mdc ? n - 1 : n;
                if (idx >= 0 && idx < 64) begin
                    exp_oe = !(is_rd_exp && idx >= 46);
                    if (mdio_oe !== exp_oe) oe_bad++;
                end
            end else if (mdio_oe) begin
                oe_bad++;
            end
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic begin_frame(input bit is_read);
        bits.delete();
        last_rise = -1;
        r10_bad   = 0;
        oe_bad    = 0;
        per_bad   = 0;
        is_rd_exp = is_read;
    endtask

    task automatic finish_frame(input string tag);
        logic [31:0] s, d;
        int k;
        for (k = 0; k < 20000; k++) begin
            rdreg(A_DATA, d);
            rdreg(A_CFG, s);
            if (!d[31] && !s[0]) break;
        end
        frame_active = 0;
        chk(k < 20000, {tag, " R7 busy clears"}, k, 0);
        chk(r10_bad == 0, {tag, " R10 mdio moved while mdc high"}, r10_bad, 0);
        chk(oe_bad == 0, {tag, " R10 output enable vs bit position"}, oe_bad, 0);
        chk(per_bad == 0, {tag, " R2 mdc period"}, per_bad, 0);
    endtask

    task automatic cmp_frame(input logic [63:0] exp, input string tag);
        bit ok;
        int first;
        ok    = (bits.size() == 64);
        first = -1;
        for (int i = 0; i < 64 && i < bits.size(); i++) begin
            if (bits[i] != exp[63 - i]) begin
                ok = 0;
                if (first < 0) first = i;
            end
        end
        chk(ok, {tag, " frame bits (actual=bit count, expected=64; first bad bit index printed below)"}, bits.size(), 64);
        if (!ok) $display("  first mismatching bit index %0d", first);
    endtask

    function automatic logic [63:0] frame(input logic [1:0] st, input logic [1:0] op,
                                          input logic [4:0] p, input logic [4:0] dv,
                                          input logic [15:0] dat);
        return {32'hFFFF_FFFF, st, op, p, dv, 2'b10, dat};
    endfunction

    initial begin
        logic [31:0] v;
        int rc;
        rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        phy_drv = 0; phy_val = 1;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        rdreg(A_CFG, v);
        chk(v == 32'h0000_0080, "R1 config after reset", v, 32'h80);
        chk(mdc == 0, "R1 mdc low", mdc, 0);
        chk(mdio_oe == 0, "R1 mdio released", mdio_oe, 0);

        // R2 divider zero: no launch
        wr(A_DATA, 32'h1234);
        repeat (20) @(negedge clk);
        rdreg(A_DATA, v);
        chk(v == 32'h0000_1234, "R2 div0 data stored, not busy", v, 32'h1234);
        chk(rise_cnt == 0, "R2 div0 mdc stays low", rise_cnt, 0);

        // R11 polarity bit
        wr(A_CFG, 32'h0002_0080); exp_div = 2;
        rdreg(A_CFG, v);
        chk(v == 32'h0002_0080, "R11 config readback", v, 32'h0002_0080);
        wr(A_CFG, 32'h0002_0000);
        rdreg(A_CFG, v);
        chk(v == 32'h0002_0000, "R11 polarity cleared", v, 32'h0002_0000);
        wr(A_CFG, 32'h0002_0080);

        // R3 short-address write
        wr(A_CTRL, 32'h0000_00AA);
        rdreg(A_CTRL, v);
        chk(v == 32'h0000_00AA, "R3 control readback", v, 32'hAA);
        begin_frame(0);
        wr(A_DATA, 32'h0000_BEEF); frame_active = 1;
        rdreg(A_DATA, v);
        chk(v[31] == 1, "R7 data busy during write", v[31], 1);
        rdreg(A_CFG, v);
        chk(v[0] == 0, "R7 address busy clear during write", v[0], 0);
        finish_frame("R3 c22 write");
        cmp_frame(frame(2'b01, 2'b01, 5'd5, 5'd10, 16'hBEEF), "R3");
        rdreg(A_DATA, v);
        chk(v == 32'h0000_BEEF, "R7 data word after write", v, 32'hBEEF);

        // R4 short-address read
        respond = 1; resp = 16'h5A3C;
        begin_frame(1);
        wr(A_CTRL, 32'h0000_80AA); frame_active = 1;
        rdreg(A_DATA, v);
        chk(v[31] == 1, "R7 data busy during read", v[31], 1);
        finish_frame("R4 c22 read");
        cmp_frame(frame(2'b01, 2'b10, 5'd5, 5'd10, 16'h5A3C), "R4");
        rdreg(A_DATA, v);
        chk(v == 32'h0000_5A3C, "R4 read data", v, 32'h5A3C);
        rdreg(A_CFG, v);
        chk(v[1] == 0, "R8 no error on answered read", v[1], 0);

        // R8 unanswered read
        respond = 0;
        begin_frame(1);
        wr(A_CTRL, 32'h0000_80AA); frame_active = 1;
        finish_frame("R8 no answer");
        rdreg(A_CFG, v);
        chk(v[1] == 1, "R8 error flag set", v[1], 1);
        rdreg(A_DATA, v);
        chk(v == 32'h0000_FFFF, "R8 all ones on error", v, 32'hFFFF);

        respond = 1; resp = 16'h0F0F;
        begin_frame(1);
        wr(A_CTRL, 32'h0000_80AA); frame_active = 1;
        rdreg(A_CFG, v);
        chk(v[1] == 0, "R8 error clears at next read start", v[1], 0);
        finish_frame("R8 recovery");
        rdreg(A_DATA, v);
        chk(v == 32'h0000_0F0F, "R8 data after recovery", v, 32'h0F0F);

        // R5 extended address frame
        wr(A_CFG, 32'h0003_00C0); exp_div = 3;
        wr(A_CTRL, 32'h0000_0061);
        begin_frame(0);
        wr(A_ADDR, 32'h0000_0C0A); frame_active = 1;
        rdreg(A_CFG, v);
        chk(v[0] == 1, "R5 address busy set", v[0], 1);
        rdreg(A_DATA, v);
        chk(v[31] == 0, "R5 data busy clear in address frame", v[31], 0);
        finish_frame("R5 c45 address");
        cmp_frame(frame(2'b00, 2'b00, 5'd3, 5'd1, 16'h0C0A), "R5");

        // R6 extended write, with R9 writes during the frame
        begin_frame(0);
        wr(A_DATA, 32'h0000_1357); frame_active = 1;
        wr(A_CTRL, 32'h0000_83FF);
        wr(A_ADDR, 32'h0000_FFFF);
        wr(A_CFG, 32'h0000_0000);
        wr(A_DATA, 32'h0000_0000);
        finish_frame("R6 c45 write");
        cmp_frame(frame(2'b00, 2'b01, 5'd3, 5'd1, 16'h1357), "R6 write");
        rdreg(A_CTRL, v);
        chk(v == 32'h0000_0061, "R9 control kept", v, 32'h61);
        rdreg(A_ADDR, v);
        chk(v == 32'h0000_0C0A, "R9 address kept", v, 32'h0C0A);
        rdreg(A_CFG, v);
        chk((v & 32'h01FF_00C0) == 32'h0003_00C0, "R9 config kept", v, 32'h0003_00C0);
        rdreg(A_DATA, v);
        chk(v == 32'h0000_1357, "R9 data kept", v, 32'h1357);
        rc = rise_cnt;
        repeat (50) @(negedge clk);
        chk(rise_cnt == rc, "R9 no extra frame", rise_cnt, rc);

        // R6 extended read
        resp = 16'h2468;
        begin_frame(1);
        wr(A_CTRL, 32'h0000_8061); frame_active = 1;
        finish_frame("R6 c45 read");
        cmp_frame(frame(2'b00, 2'b11, 5'd3, 5'd1, 16'h2468), "R6 read");
        rdreg(A_DATA, v);
        chk(v == 32'h0000_2468, "R6 read data", v, 32'h2468);

        // R5 short mode address write only stores
        wr(A_CFG, 32'h0002_0080); exp_div = 2;
        rc = rise_cnt;
        wr(A_ADDR, 32'h0000_1111);
        repeat (20) @(negedge clk);
        rdreg(A_CFG, v);
        chk(v[0] == 0, "R5 no address frame in c22", v[0], 0);
        chk(rise_cnt == rc, "R5 no mdc activity in c22", rise_cnt, rc);
        rdreg(A_ADDR, v);
        chk(v == 32'h0000_1111, "R5 address stored in c22", v, 32'h1111);

        summary();
        $finish;
    end

endmodule